// File: doc/BRIEF.md
# Hardware Ring Cutoff Override

This block gives a line card a fast way to stop ringing that does not wait for software. Five pin drive values come from software output registers: three dedicated outputs and two bidirectional pins. Normally the block passes them straight through. When the function is enabled, the block watches one of two debounced line-status inputs for the off-hook condition. If that condition is seen while the chosen ring control pin sits at its ringing level, the block inverts that pin to its idle level. It does this regardless of the register value.

The override is latched. It holds after the off-hook indication goes away. It releases as soon as one of these happens: software writes the register to the idle level, the enable is cleared, the target selection changes, or the chosen bidirectional pin stops being an output. Input polarity and output polarity are programmed separately, so any active-high or active-low pairing of line status and ring control can be served.

Top module: `ring_cutoff_ovr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `pin_drv` bit equals the matching `reg_drv` bit.
- R2: With `cfg_en` low, `pin_drv` equals `reg_drv` whatever the inputs do.
- R3: `cfg_in_sel` picks the watched input (0: `sense_in[0]`, 1: `sense_in[1]`); activity on the other input has no effect.
- R4: Off-hook is `sense_in[cfg_in_sel] == cfg_in_pol` (0: active low, 1: active high). The override can begin only in the cycle after off-hook was sampled with `cfg_en` high.
- R5: The ringing level of the target pin is `cfg_out_pol` (1: rings high, 0: rings low). A trip happens only if the target register bit is at that level, and the overridden pin is driven to the opposite level.
- R6: Target codes of `cfg_out_sel`: 0,1,2 select `reg_drv[0..2]` (dedicated outputs), 3 and 4 select `reg_drv[3]` and `reg_drv[4]` (bidirectional). A trip inverts only the target bit, one clock after the off-hook sample. At most one `pin_drv` bit ever differs from `reg_drv`.
- R7: Once tripped, the override holds after the input returns on-hook.
- R8: The override releases at once (same cycle) and stays released when the target register bit goes to its idle level, when `cfg_en` falls, or when `cfg_out_sel` changes.
- R9: A bidirectional target (codes 3, 4) is valid only while its `bidir_oe` bit (`bidir_oe[0]` for code 3, `bidir_oe[1]` for code 4) is 1. Otherwise it never trips, and an active override on it releases.
- R10: Codes 5, 6 and 7 select no pin, and `pin_drv` equals `reg_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables the hardware cutoff |
| cfg_in_sel | input | 1 | Picks the off-hook input |
| cfg_out_sel | input | 3 | Target pin code |
| cfg_in_pol | input | 1 | Off-hook active level |
| cfg_out_pol | input | 1 | Ringing level of the target pin |
| sense_in | input | 2 | Debounced line-status inputs |
| reg_drv | input | 5 | Software output register values |
| bidir_oe | input | 2 | Output enables of the two bidirectional pins |
| pin_drv | output | 5 | Final pin drive values |

## Verification
The bench attacks the points where a plausible design goes wrong. An off-hook pulse that ends before software reacts would expose a design that does not latch, because the ring would resume. A register written to idle would expose a design that releases one cycle late, because it would glitch the pin back to the ringing level for a cycle. A bidirectional pin configured as an input, or a reserved code, would expose a design that trips the wrong pin or a pin it must not drive. Swapped polarities would expose an inverted comparison, which trips on hang-up or never trips at all. A long randomized run then compares every cycle against a behavioural model, which catches a stale target and cross-talk between the two inputs.

// File: rtl/rco_pkg.sv
package rco_pkg;
    localparam int N_IN  = 2;
    localparam int N_DED = 3;
    localparam int N_BID = 2;
    localparam int N_OUT = N_DED + N_BID;
    localparam int ISEL_W = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int OSEL_W = $clog2(N_OUT + 3);

    typedef struct packed {
        logic             active;
        logic [N_OUT-1:0] tgt_oh;
    } trip_state_t;

    // True when any bit picked by mask sits at the ringing level
    function automatic logic at_ring_level(input logic [N_OUT-1:0] mask,
                                           input logic [N_OUT-1:0] regs,
                                           input logic             ring_lvl);
        return |(mask & ~(regs ^ {N_OUT{ring_lvl}}));
    endfunction
endpackage

// File: rtl/rco_hook_detect.sv
module rco_hook_detect
    import rco_pkg::*;
#(
    parameter int NI = N_IN,
    localparam int SW = (NI > 1) ? $clog2(NI) : 1
) (
    input  logic [NI-1:0] sense_in,
    input  logic [SW-1:0] in_sel,
    input  logic          in_pol,
    output logic          off_hook
);
    always_comb begin
        off_hook = (sense_in[in_sel] == in_pol);
    end
endmodule

// File: rtl/rco_target_dec.sv
module rco_target_dec
    import rco_pkg::*;
#(
    parameter int ND = N_DED,
    parameter int NB = N_BID,
    localparam int NO = ND + NB,
    localparam int SW = $clog2(NO + 3)
) (
    input  logic [SW-1:0] out_sel,
    input  logic [NB-1:0] bidir_oe,
    output logic [NO-1:0] tgt_oh
);
    for (genvar g = 0; g < NO; g++) begin : g_tgt
        if (g < ND) begin : g_ded
            assign tgt_oh[g] = (out_sel == SW'(g));
        end else begin : g_bid
            assign tgt_oh[g] = (out_sel == SW'(g)) && bidir_oe[g-ND];
        end
    end
endmodule

// File: rtl/rco_trip_latch.sv
module rco_trip_latch
    import rco_pkg::*;
#(
    parameter int NO = N_OUT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          off_hook,
    input  logic          ring_lvl,
    input  logic [NO-1:0] tgt_oh,
    input  logic [NO-1:0] regs,
    output logic [NO-1:0] flip_mask
);
    trip_state_t st_d, st_q;
    logic hold;
    logic arm;

    always_comb begin
        st_d = st_q;
        hold = st_q.active && en && (st_q.tgt_oh == tgt_oh)
               && at_ring_level(st_q.tgt_oh, regs, ring_lvl);
        arm  = en && off_hook && at_ring_level(tgt_oh, regs, ring_lvl);
        if (hold) begin
            st_d = st_q;
        end else if (arm) begin
            st_d.active = 1'b1;
            st_d.tgt_oh = tgt_oh;
        end else begin
            st_d.active = 1'b0;
            st_d.tgt_oh = '0;
        end
        flip_mask = hold ? st_q.tgt_oh : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rco_pin_mux.sv
module rco_pin_mux
    import rco_pkg::*;
#(
    parameter int NO = N_OUT
) (
    input  logic [NO-1:0] regs,
    input  logic [NO-1:0] flip_mask,
    output logic [NO-1:0] pins
);
    for (genvar g = 0; g < NO; g++) begin : g_pin
        assign pins[g] = flip_mask[g] ? ~regs[g] : regs[g];
    end
endmodule

// File: rtl/ring_cutoff_ovr.sv
module ring_cutoff_ovr
    import rco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [ISEL_W-1:0] cfg_in_sel,
    input  logic [OSEL_W-1:0] cfg_out_sel,
    input  logic              cfg_in_pol,
    input  logic              cfg_out_pol,
    input  logic [N_IN-1:0]   sense_in,
    input  logic [N_OUT-1:0]  reg_drv,
    input  logic [N_BID-1:0]  bidir_oe,
    output logic [N_OUT-1:0]  pin_drv
);
    logic             off_hook;
    logic [N_OUT-1:0] tgt_oh;
    logic [N_OUT-1:0] flip_mask;

    rco_hook_detect #(.NI(N_IN)) u_det (
        .sense_in (sense_in),
        .in_sel   (cfg_in_sel),
        .in_pol   (cfg_in_pol),
        .off_hook (off_hook)
    );

    rco_target_dec #(.ND(N_DED), .NB(N_BID)) u_dec (
        .out_sel  (cfg_out_sel),
        .bidir_oe (bidir_oe),
        .tgt_oh   (tgt_oh)
    );

    rco_trip_latch #(.NO(N_OUT)) u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .off_hook  (off_hook),
        .ring_lvl  (cfg_out_pol),
        .tgt_oh    (tgt_oh),
        .regs      (reg_drv),
        .flip_mask (flip_mask)
    );

    rco_pin_mux #(.NO(N_OUT)) u_mux (
        .regs      (reg_drv),
        .flip_mask (flip_mask),
        .pins      (pin_drv)
    );
endmodule

// File: rtl/ring_cutoff_ovr_chk.sv
module ring_cutoff_ovr_chk
    import rco_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [ISEL_W-1:0] cfg_in_sel,
    input logic [OSEL_W-1:0] cfg_out_sel,
    input logic              cfg_in_pol,
    input logic              cfg_out_pol,
    input logic [N_IN-1:0]   sense_in,
    input logic [N_OUT-1:0]  reg_drv,
    input logic [N_BID-1:0]  bidir_oe,
    input logic [N_OUT-1:0]  pin_drv
);
    logic [N_OUT-1:0] diff;
    logic             hooked;
    assign diff   = pin_drv ^ reg_drv;
    assign hooked = cfg_en && (sense_in[cfg_in_sel] == cfg_in_pol);

    assert_pass_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (pin_drv == reg_drv));

    assert_reserved_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_sel > OSEL_W'(N_OUT - 1)) |-> (pin_drv == reg_drv));

    assert_bidir_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_out_sel == OSEL_W'(N_DED)) && !bidir_oe[0]) |-> (pin_drv == reg_drv));

    assert_single_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(diff));

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (diff != '0) |-> (((pin_drv & diff) == '0) == cfg_out_pol));

    assert_trip_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((diff != '0) && $past(pin_drv == reg_drv)) |-> $past(hooked));
endmodule

bind ring_cutoff_ovr ring_cutoff_ovr_chk u_chk (.*);

// File: tb/ring_cutoff_ovr_test.sv
module ring_cutoff_ovr_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_in_sel = 1'b0;
    logic [2:0] cfg_out_sel = 3'd0;
    logic       cfg_in_pol = 1'b0;
    logic       cfg_out_pol = 1'b1;
    logic [1:0] sense_in = 2'b11;
    logic [4:0] reg_drv = 5'b00000;
    logic [1:0] bidir_oe = 2'b00;
    logic [4:0] pin_drv;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_on = 1'b0;
    int m_tgt = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_cutoff_ovr uut (.*);

    function automatic bit pin_ok(int t);
        if (t < 0 || t > 4) return 1'b0;
        if (t < 3) return 1'b1;
        return bidir_oe[t-3];
    endfunction

    function automatic bit ringing(int t);
        return pin_ok(t) && (reg_drv[t] == cfg_out_pol);
    endfunction

    function automatic bit still_held();
        return m_on && cfg_en && (int'(cfg_out_sel) == m_tgt) && ringing(m_tgt);
    endfunction

    function automatic logic [4:0] expect_pins();
        logic [4:0] e = reg_drv;
        if (still_held()) e[m_tgt] = ~cfg_out_pol;
        return e;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_on = 1'b0; m_tgt = -1;
        end else if (still_held()) begin
            m_on = 1'b1;
        end else if (cfg_en && (sense_in[cfg_in_sel] == cfg_in_pol)
                     && ringing(int'(cfg_out_sel))) begin
            m_on = 1'b1; m_tgt = int'(cfg_out_sel);
        end else begin
            m_on = 1'b0; m_tgt = -1;
        end
    end

    task automatic chk(string req, logic [4:0] exp);
        n_chk++;
        if (pin_drv !== exp) begin
            n_err++;
            $display("FAIL %s: pin_drv=%b expected=%b at %0t", req, pin_drv, exp, $time);
        end
    endtask

    // wait one cycle, compare with the model, then optionally a literal value
    task automatic tick(string req);
        @(negedge clk);
        chk(req, expect_pins());
    endtask

    task automatic tick_lit(string req, logic [4:0] exp);
        @(negedge clk);
        chk(req, expect_pins());
        chk(req, exp);
    endtask

    task automatic setup(bit ip, bit op, bit isel, int osel, logic [1:0] idle);
        cfg_en = 1'b1; cfg_in_pol = ip; cfg_out_pol = op;
        cfg_in_sel = isel; cfg_out_sel = 3'(osel); sense_in = idle;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        reg_drv = 5'b00001;
        @(negedge clk);
        chk("R1", 5'b00001);
        rst_n = 1'b1;
        tick_lit("R1", 5'b00001);

        // R6/R7/R8: active-low hook, ring high on dedicated pin 0
        setup(1'b0, 1'b1, 1'b0, 0, 2'b11);
        reg_drv = 5'b10001;
        tick_lit("R6", 5'b10001);
        sense_in = 2'b10;
        tick_lit("R6", 5'b10000);
        sense_in = 2'b11;
        tick_lit("R7", 5'b10000);
        tick_lit("R7", 5'b10000);
        reg_drv = 5'b10000;
        tick_lit("R8", 5'b10000);
        reg_drv = 5'b10001;
        tick_lit("R8", 5'b10001);

        // R2: disabled
        cfg_en = 1'b0; sense_in = 2'b10;
        tick_lit("R2", 5'b10001);
        sense_in = 2'b11;
        tick_lit("R2", 5'b10001);

        // R3: other input ignored
        cfg_en = 1'b1; sense_in = 2'b01;
        tick_lit("R3", 5'b10001);
        sense_in = 2'b11;
        tick_lit("R3", 5'b10001);
        cfg_in_sel = 1'b1; sense_in = 2'b01;
        tick_lit("R3", 5'b10000);
        sense_in = 2'b11;
        // R8: release on enable clear
        cfg_en = 1'b0;
        tick_lit("R8", 5'b10001);
        cfg_en = 1'b1;
        tick_lit("R8", 5'b10001);

        // R4: active-high hook on input 0, pin 2
        setup(1'b1, 1'b1, 1'b0, 2, 2'b00);
        reg_drv = 5'b00100;
        tick_lit("R4", 5'b00100);
        sense_in = 2'b01;
        tick_lit("R4", 5'b00000);
        // R8: release on select change
        sense_in = 2'b00; cfg_out_sel = 3'd1;
        tick_lit("R8", 5'b00100);
        cfg_out_sel = 3'd2;
        tick_lit("R8", 5'b00100);

        // R5: ring-low target pin 1
        setup(1'b0, 1'b0, 1'b0, 1, 2'b11);
        reg_drv = 5'b11111;
        sense_in = 2'b10;
        tick_lit("R5", 5'b11111);
        reg_drv = 5'b11101;
        tick_lit("R5", 5'b11111);
        sense_in = 2'b11; reg_drv = 5'b11111;
        tick_lit("R5", 5'b11111);

        // R9: bidirectional pin 3
        setup(1'b0, 1'b1, 1'b0, 3, 2'b11);
        bidir_oe = 2'b00; reg_drv = 5'b01000;
        sense_in = 2'b10;
        tick_lit("R9", 5'b01000);
        tick_lit("R9", 5'b01000);
        bidir_oe = 2'b01;
        tick_lit("R9", 5'b00000);
        sense_in = 2'b11;
        bidir_oe = 2'b00;
        tick_lit("R9", 5'b01000);
        cfg_out_sel = 3'd4; bidir_oe = 2'b10; reg_drv = 5'b10000; sense_in = 2'b10;
        tick_lit("R9", 5'b00000);
        sense_in = 2'b11;

        // R10: reserved codes
        for (int c = 5; c < 8; c++) begin
            cfg_out_sel = 3'(c); reg_drv = 5'b11111; bidir_oe = 2'b11; sense_in = 2'b10;
            tick_lit("R10", 5'b11111);
            cfg_out_pol = 1'b0; reg_drv = 5'b00000;
            tick_lit("R10", 5'b00000);
            cfg_out_pol = 1'b1; sense_in = 2'b11;
        end

        // randomized traffic against the model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) cfg_en = ~cfg_en;
            if ($urandom_range(0, 31) == 0) cfg_out_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 31) == 0) cfg_in_sel = ~cfg_in_sel;
            if ($urandom_range(0, 63) == 0) cfg_in_pol = ~cfg_in_pol;
            if ($urandom_range(0, 63) == 0) cfg_out_pol = ~cfg_out_pol;
            if ($urandom_range(0, 3) == 0) sense_in = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) reg_drv = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 31) == 0) bidir_oe = 2'($urandom_range(0, 3));
            tick("R6");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule